// File: doc/BRIEF.md
# Rectangle Corner Kernel Accumulator

This block builds one tile of a partial aerial image. The layout is described as a list of rectangles. For every rectangle the block adds signed, shifted copies of a chosen kernel array into a tile-sized memory of partial sums. Each rectangle is handled through its four corners. For one fixed corner the block visits every pixel of the tile in raster order. It fetches the kernel sample found at the pixel position minus the corner position, and adds that sample to the pixel's partial sum or subtracts it. The corners alternate in sign, so the summed shifted kernels reproduce the kernel's response to the whole rectangle area.

Kernel tables are written into an internal kernel RAM before use, through a simple write port. A clear command zeroes the partial sums. Rectangles then arrive on a valid/ready handshake, together with a kernel-select index. One pixel update is issued per clock, and a single-cycle done pulse marks the end of each rectangle. While the block is idle the partial sums can be read back through a registered read port. The block holds exactly one partition of the image and writes only to it. Squaring the fields, weighting across kernels and producing the kernels are left to other logic.

Top module: `rect_corner_acc`

## Requirements
- R1: The corners of a rectangle are processed in the order (x1,y1), (x2,y1), (x2,y2), (x1,y2). They add, subtract, add and subtract their kernel sample in that order. A rectangle with x1=x2 and y1=y2 therefore leaves every partial sum unchanged.
- R2: Tile pixel (col,row) sits at image coordinate (TILE_X0+col, TILE_Y0+row), and its read-back index is row*TILE_W+col. For corner (cx,cy) it uses kernel sample (kx,ky) = (px-cx, py-cy). That sample is held at kernel RAM address sel*KER_W*KER_H + ky*KER_W + kx.
- R3: When kx or ky falls outside 0..KER_W-1 or 0..KER_H-1, the term contributes zero and no kernel RAM read is issued.
- R4: `rect_ready_o` is high only when the block is idle, no update is still in flight and `clr_i` is low. A rectangle is taken on the edge where valid and ready are both high. Ready then stays low until the done pulse.
- R5: `done_o` rises exactly 4*TILE_W*TILE_H+1 clock edges after the edge that accepts a rectangle, with one pixel update issued per clock.
- R6: Partial sums are signed PSUM_W-bit (24) values. Each update saturates at +(2^23-1) and -(2^23), and the clamp is applied per corner term in processing order. Kernel samples are signed 16-bit values.
- R7: When `clr_i` is high in idle it takes priority over a pending rectangle. The block then writes zero to every partial sum, one per clock, keeps ready low and gives no done pulse.
- R8: Partial sums persist from one rectangle to the next, and `ker_sel_i`, captured with the rectangle, chooses the kernel table that is used.
- R9: While idle, `rd_data_o` shows the partial sum at `rd_addr_i` one clock after the address is applied.
- R10: `done_o` is a single-cycle pulse, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Zero all partial sums (idle only) |
| rect_valid_i | input | 1 | Rectangle offered |
| rect_ready_o | output | 1 | Block can take a rectangle |
| rect_x1_i | input | CW | Signed first x edge |
| rect_y1_i | input | CW | Signed first y edge |
| rect_x2_i | input | CW | Signed second x edge |
| rect_y2_i | input | CW | Signed second y edge |
| ker_sel_i | input | KSW | Kernel table index |
| kwr_en_i | input | 1 | Kernel RAM write strobe |
| kwr_addr_i | input | KAW | Kernel RAM write address |
| kwr_data_i | input | KW | Signed kernel sample to write |
| rd_addr_i | input | PAW | Partial-sum read-back index |
| rd_data_o | output | PSUM_W | Partial sum read back |
| done_o | output | 1 | Rectangle finished pulse |

## Verification
The bench targets three risks: the corner order and signs, the shifted kernel addressing near the edges of the kernel extent, and the saturating arithmetic. A wrong sign or a swapped corner leaves non-zero residue where a degenerate rectangle should cancel. An off-by-one shift shows up as misplaced values in the readback. Without a zero for out-of-extent samples, a rectangle far outside the kernel would change the tile. The bench drives sums past both clamps and then steps back. A wrapping adder would flip sign there, and a clamp applied only once per rectangle would land on a different value. Further checks cover the exact done latency, ready held low while busy, and a clear that wins over a rectangle offered in the same cycle.

// File: rtl/rca_pkg.sv
`timescale 1ns/1ps
package rca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CLR  = 2'd2
    } rca_state_e;

    // corners 0 and 2 add, corners 1 and 3 subtract
    function automatic logic corner_adds(input logic [1:0] crn);
        return ~crn[0];
    endfunction
endpackage

// File: rtl/rca_sweep.sv
`timescale 1ns/1ps
module rca_sweep
    import rca_pkg::*;
#(
    parameter int TILE_W  = 4,
    parameter int TILE_H  = 4,
    parameter int KER_W   = 8,
    parameter int KER_H   = 8,
    parameter int NUM_KER = 2,
    parameter int CW      = 10,
    parameter int TILE_X0 = 0,
    parameter int TILE_Y0 = 0,
    localparam int NPIX   = TILE_W * TILE_H,
    localparam int PAW    = (NPIX > 1) ? $clog2(NPIX) : 1,
    localparam int KAW    = (NUM_KER * KER_W * KER_H > 1) ? $clog2(NUM_KER * KER_W * KER_H) : 1,
    localparam int KSW    = (NUM_KER > 1) ? $clog2(NUM_KER) : 1,
    localparam int CLW    = (TILE_W > 1) ? $clog2(TILE_W) : 1,
    localparam int RLW    = (TILE_H > 1) ? $clog2(TILE_H) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 rect_valid_i,
    input  logic signed [CW-1:0] x1_i,
    input  logic signed [CW-1:0] y1_i,
    input  logic signed [CW-1:0] x2_i,
    input  logic signed [CW-1:0] y2_i,
    input  logic [KSW-1:0]       ksel_i,
    input  logic                 pipe_busy_i,
    output logic                 ready_o,
    output logic                 iss_valid_o,
    output logic                 iss_add_o,
    output logic                 iss_inr_o,
    output logic                 iss_last_o,
    output logic [KAW-1:0]       iss_kaddr_o,
    output logic [PAW-1:0]       iss_paddr_o,
    output logic                 clr_we_o
);
    typedef struct packed {
        rca_state_e           st;
        logic [1:0]           crn;
        logic [CLW-1:0]       col;
        logic [RLW-1:0]       row;
        logic [KSW-1:0]       ks;
        logic signed [CW-1:0] x1, y1, x2, y2;
    } sweep_t;

    sweep_t q, d;
    logic signed [CW-1:0] cx, cy;
    int kxi, kyi;
    logic col_end, row_end;

    always_comb begin
        d = q;
        // corner coordinate selection: 0=(x1,y1) 1=(x2,y1) 2=(x2,y2) 3=(x1,y2)
        cx = (q.crn == 2'd0 || q.crn == 2'd3) ? q.x1 : q.x2;
        cy = (q.crn[1] == 1'b0) ? q.y1 : q.y2;
        kxi = TILE_X0 + int'(q.col) - int'(cx);
        kyi = TILE_Y0 + int'(q.row) - int'(cy);
        col_end = (q.col == CLW'(TILE_W - 1));
        row_end = (q.row == RLW'(TILE_H - 1));

        ready_o     = (q.st == ST_IDLE) && !pipe_busy_i && !clr_i;
        iss_valid_o = (q.st == ST_RUN);
        clr_we_o    = (q.st == ST_CLR);
        iss_add_o   = corner_adds(q.crn);
        iss_inr_o   = (kxi >= 0) && (kxi < KER_W) && (kyi >= 0) && (kyi < KER_H);
        iss_kaddr_o = KAW'(int'(q.ks) * KER_W * KER_H + kyi * KER_W + kxi);
        iss_paddr_o = PAW'(int'(q.row) * TILE_W + int'(q.col));
        iss_last_o  = iss_valid_o && (q.crn == 2'd3) && col_end && row_end;

        if (q.st == ST_RUN || q.st == ST_CLR) begin
            d.col = col_end ? '0 : q.col + 1'b1;
            if (col_end) begin
                d.row = row_end ? '0 : q.row + 1'b1;
                if (row_end) begin
                    if (q.st == ST_CLR || q.crn == 2'd3) begin
                        d.st  = ST_IDLE;
                        d.crn = '0;
                    end else begin
                        d.crn = q.crn + 2'd1;
                    end
                end
            end
        end else begin
            if (clr_i && !pipe_busy_i) begin
                d.st  = ST_CLR;
                d.col = '0;
                d.row = '0;
            end else if (rect_valid_i && ready_o) begin
                d.st  = ST_RUN;
                d.crn = '0;
                d.col = '0;
                d.row = '0;
                d.ks  = ksel_i;
                d.x1  = x1_i;
                d.y1  = y1_i;
                d.x2  = x2_i;
                d.y2  = y2_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rca_kmem.sv
`timescale 1ns/1ps
module rca_kmem #(
    parameter int DEPTH = 128,
    parameter int DW    = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        if (re_i) rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/rca_pmem.sv
`timescale 1ns/1ps
module rca_pmem #(
    parameter int DEPTH = 16,
    parameter int DW    = 24,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem [DEPTH];

    // read returns the stored value; a same-cycle write is seen next cycle
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/rect_corner_acc.sv
`timescale 1ns/1ps
module rect_corner_acc
    import rca_pkg::*;
#(
    parameter int TILE_W  = 4,
    parameter int TILE_H  = 4,
    parameter int KER_W   = 8,
    parameter int KER_H   = 8,
    parameter int NUM_KER = 2,
    parameter int CW      = 10,
    parameter int KW      = 16,
    parameter int PSUM_W  = 24,
    parameter int TILE_X0 = 0,
    parameter int TILE_Y0 = 0,
    localparam int NPIX   = TILE_W * TILE_H,
    localparam int KDEPTH = NUM_KER * KER_W * KER_H,
    localparam int PAW    = (NPIX > 1) ? $clog2(NPIX) : 1,
    localparam int KAW    = (KDEPTH > 1) ? $clog2(KDEPTH) : 1,
    localparam int KSW    = (NUM_KER > 1) ? $clog2(NUM_KER) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 rect_valid_i,
    output logic                 rect_ready_o,
    input  logic signed [CW-1:0] rect_x1_i,
    input  logic signed [CW-1:0] rect_y1_i,
    input  logic signed [CW-1:0] rect_x2_i,
    input  logic signed [CW-1:0] rect_y2_i,
    input  logic [KSW-1:0]       ker_sel_i,
    input  logic                 kwr_en_i,
    input  logic [KAW-1:0]       kwr_addr_i,
    input  logic [KW-1:0]        kwr_data_i,
    input  logic [PAW-1:0]       rd_addr_i,
    output logic [PSUM_W-1:0]    rd_data_o,
    output logic                 done_o
);
    typedef struct packed {
        logic           valid;
        logic           add;
        logic           inr;
        logic           last;
        logic [PAW-1:0] paddr;
    } stage_t;

    typedef struct packed {
        logic              valid;
        logic [PAW-1:0]    addr;
        logic [PSUM_W-1:0] data;
    } fwd_t;

    typedef struct packed {
        stage_t s1;
        fwd_t   fw;
        logic   done;
    } acc_t;

    acc_t q, d;

    logic                 iss_valid, iss_add, iss_inr, iss_last, clr_we;
    logic [KAW-1:0]       iss_kaddr;
    logic [PAW-1:0]       iss_paddr;
    logic [KW-1:0]        km_rdata;
    logic [PSUM_W-1:0]    pm_rdata;
    logic                 pm_we;
    logic [PAW-1:0]       pm_waddr;
    logic [PSUM_W-1:0]    pm_wdata;

    logic                     upd_en, acc_add;
    logic signed [PSUM_W-1:0] acc_old, acc_term, acc_new;
    logic signed [PSUM_W:0]   acc_sum;

    rca_sweep #(
        .TILE_W(TILE_W), .TILE_H(TILE_H), .KER_W(KER_W), .KER_H(KER_H),
        .NUM_KER(NUM_KER), .CW(CW), .TILE_X0(TILE_X0), .TILE_Y0(TILE_Y0)
    ) u_sweep (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .rect_valid_i(rect_valid_i),
        .x1_i(rect_x1_i), .y1_i(rect_y1_i), .x2_i(rect_x2_i), .y2_i(rect_y2_i),
        .ksel_i(ker_sel_i), .pipe_busy_i(q.s1.valid), .ready_o(rect_ready_o),
        .iss_valid_o(iss_valid), .iss_add_o(iss_add), .iss_inr_o(iss_inr),
        .iss_last_o(iss_last), .iss_kaddr_o(iss_kaddr), .iss_paddr_o(iss_paddr),
        .clr_we_o(clr_we)
    );

    rca_kmem #(.DEPTH(KDEPTH), .DW(KW)) u_kmem (
        .clk(clk), .we_i(kwr_en_i), .waddr_i(kwr_addr_i), .wdata_i(kwr_data_i),
        .re_i(iss_valid && iss_inr), .raddr_i(iss_kaddr), .rdata_o(km_rdata)
    );

    rca_pmem #(.DEPTH(NPIX), .DW(PSUM_W)) u_pmem (
        .clk(clk), .we_i(pm_we), .waddr_i(pm_waddr), .wdata_i(pm_wdata),
        .raddr_i(iss_valid ? iss_paddr : rd_addr_i), .rdata_o(pm_rdata)
    );

    always_comb begin
        d = q;
        // stage 1: read-modify-write with forwarding of the previous write
        upd_en   = q.s1.valid;
        acc_add  = q.s1.add;
        acc_old  = (q.fw.valid && q.fw.addr == q.s1.paddr) ? q.fw.data : pm_rdata;
        acc_term = q.s1.inr ? {{(PSUM_W - KW){km_rdata[KW-1]}}, km_rdata} : '0;
        acc_sum  = acc_add ? {acc_old[PSUM_W-1], acc_old} + {acc_term[PSUM_W-1], acc_term}
                           : {acc_old[PSUM_W-1], acc_old} - {acc_term[PSUM_W-1], acc_term};
        if (acc_sum[PSUM_W] != acc_sum[PSUM_W-1])
            acc_new = acc_sum[PSUM_W] ? {1'b1, {(PSUM_W-1){1'b0}}} : {1'b0, {(PSUM_W-1){1'b1}}};
        else
            acc_new = acc_sum[PSUM_W-1:0];

        pm_we    = upd_en || clr_we;
        pm_waddr = clr_we ? iss_paddr : q.s1.paddr;
        pm_wdata = clr_we ? '0 : acc_new;

        d.s1.valid = iss_valid;
        d.s1.add   = iss_add;
        d.s1.inr   = iss_inr;
        d.s1.last  = iss_last;
        d.s1.paddr = iss_paddr;
        d.fw.valid = pm_we;
        d.fw.addr  = pm_waddr;
        d.fw.data  = pm_wdata;
        d.done     = q.s1.valid && q.s1.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data_o = pm_rdata;
    assign done_o    = q.done;
endmodule

// File: rtl/rca_chk.sv
`timescale 1ns/1ps
module rca_chk #(
    parameter int PSUM_W = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rect_valid_i,
    input logic                     rect_ready_o,
    input logic                     done_o,
    input logic                     upd_en,
    input logic                     acc_add,
    input logic signed [PSUM_W-1:0] acc_old,
    input logic signed [PSUM_W-1:0] acc_term,
    input logic signed [PSUM_W-1:0] acc_new
);
    // R4: an accepted rectangle drops ready on the next cycle
    a_r4_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rect_valid_i && rect_ready_o) |=> !rect_ready_o);

    // R10: done is one cycle wide
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: done only follows a cycle in which the block was busy
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !$past(rect_ready_o));

    // R6: a non-negative contribution never lowers the sum (no wrap)
    a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (acc_add ? (acc_term >= 0) : (acc_term <= 0))) |-> (acc_new >= acc_old));

    // R6: a non-positive contribution never raises the sum (no wrap)
    a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (acc_add ? (acc_term <= 0) : (acc_term >= 0))) |-> (acc_new <= acc_old));
endmodule

bind rect_corner_acc rca_chk #(.PSUM_W(PSUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rect_valid_i(rect_valid_i), .rect_ready_o(rect_ready_o),
    .done_o(done_o), .upd_en(upd_en), .acc_add(acc_add), .acc_old(acc_old),
    .acc_term(acc_term), .acc_new(acc_new)
);

// File: tb/sim_rect_corner_acc.sv
`timescale 1ns/1ps
module sim_rect_corner_acc;
    localparam int TW = 4, TH = 4, KXW = 8, KYH = 8, NK = 2, CW = 10, PW = 24;
    localparam int NPIX = TW * TH;
    localparam int LAT  = 4 * NPIX + 1;
    localparam int PMAX = 8388607, PMIN = -8388608;

    typedef struct packed { int ks; int x1; int y1; int x2; int y2; } vec_t;
    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{0,  0,  0,  3,  3},
        '{0, -2, -1,  2,  5},
        '{0,  1,  2, 10, 10},
        '{0, -5, -5, -1, -1},
        '{0,  3,  0,  1,  2},
        '{0,  0,  0,  0,  0},
        '{1, -3, -3,  2,  2},
        '{0, -8, -8, 20, 20}
    };

    logic clk = 0, rst_n = 0, clr = 0, rv = 0, ready, done, kwe = 0;
    logic signed [CW-1:0] x1 = '0, y1 = '0, x2 = '0, y2 = '0;
    logic [0:0] ksel = '0;
    logic [6:0] kwa = '0;
    logic [15:0] kwd = '0;
    logic [3:0] rda = '0;
    logic [PW-1:0] rdd;
    int nchk = 0, nfail = 0;
    int mdl [NPIX];

    always #2.5 clk = ~clk;

    rect_corner_acc u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .rect_valid_i(rv), .rect_ready_o(ready),
        .rect_x1_i(x1), .rect_y1_i(y1), .rect_x2_i(x2), .rect_y2_i(y2), .ker_sel_i(ksel),
        .kwr_en_i(kwe), .kwr_addr_i(kwa), .kwr_data_i(kwd), .rd_addr_i(rda),
        .rd_data_o(rdd), .done_o(done)
    );

    function automatic int kval(int s, int kx, int ky);
        return (s == 1) ? 32767 : (ky * KXW + kx) * 37 - 1000;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_rect(vec_t v);
        for (int c = 0; c < 4; c++) begin
            int cx = (c == 0 || c == 3) ? v.x1 : v.x2;
            int cy = (c < 2) ? v.y1 : v.y2;
            for (int r = 0; r < TH; r++) begin
                for (int k = 0; k < TW; k++) begin
                    int kx = k - cx, ky = r - cy, t = 0, s;
                    if (kx >= 0 && kx < KXW && ky >= 0 && ky < KYH) t = kval(v.ks, kx, ky);
                    s = (c % 2 == 0) ? mdl[r*TW+k] + t : mdl[r*TW+k] - t;
                    if (s > PMAX) s = PMAX;
                    if (s < PMIN) s = PMIN;
                    mdl[r*TW+k] = s;
                end
            end
        end
    endtask

    task automatic run_rect(vec_t v, bit check_timing);
        int n = 0;
        @(negedge clk);
        while (!ready) @(negedge clk);
        ksel = v.ks[0:0]; x1 = CW'(v.x1); y1 = CW'(v.y1); x2 = CW'(v.x2); y2 = CW'(v.y2);
        rv = 1;
        @(posedge clk);
        #1 rv = 0;
        forever begin
            @(negedge clk);
            if (check_timing && n == 0) chk(!ready, "R4 ready low while busy", ready, 0);
            if (done || n > 1000) break;
            n++;
        end
        if (check_timing) begin
            chk(n == LAT, "R5 done latency", n, LAT);
            chk(ready, "R4 ready back at done", ready, 1);
            @(negedge clk);
            chk(!done, "R10 done single pulse", done, 0);
        end
        model_rect(v);
    endtask

    task automatic readback(string req);
        for (int p = 0; p < NPIX; p++) begin
            @(negedge clk) rda = p[3:0];
            @(negedge clk);
            chk(int'($signed(rdd)) == mdl[p], req, int'($signed(rdd)), mdl[p]);
        end
    endtask

    task automatic do_clear();
        int n = 0;
        bit saw_done = 0;
        @(negedge clk);
        while (!ready) @(negedge clk);
        clr = 1; rv = 1;
        #1 chk(!ready, "R7 clear masks ready", ready, 0);
        @(posedge clk);
        #1 begin clr = 0; rv = 0; end
        @(negedge clk);
        chk(!ready, "R7 ready low during clear", ready, 0);
        while (!ready && n < 1000) begin
            @(negedge clk);
            if (done) saw_done = 1;
            n++;
        end
        chk(!saw_done, "R7 no done for clear", saw_done, 0);
        for (int p = 0; p < NPIX; p++) mdl[p] = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done, "R10 done low in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        chk(ready, "R4 ready after reset", ready, 1);
        chk(!done, "R10 done low after reset", done, 0);

        // R2 kernel layout: address sel*64 + ky*8 + kx
        for (int s = 0; s < NK; s++)
            for (int ky = 0; ky < KYH; ky++)
                for (int kx = 0; kx < KXW; kx++) begin
                    @(negedge clk);
                    kwe = 1; kwa = 7'(s * 64 + ky * KXW + kx); kwd = 16'(kval(s, kx, ky));
                end
        @(negedge clk) kwe = 0;

        do_clear();
        readback("R7 R9 cleared sums");

        // table walk: R1 R2 R3 R8 via model comparison
        for (int i = 0; i < NV; i++) begin
            run_rect(VEC[i], 1);
            readback("R1 R2 R3 R8 partial sums");
        end

        // R3: rectangle entirely off the kernel leaves sums untouched
        begin
            int keep [NPIX];
            for (int p = 0; p < NPIX; p++) keep[p] = mdl[p];
            run_rect('{1, -40, -40, 40, 40}, 1);
            for (int p = 0; p < NPIX; p++) begin
                @(negedge clk) rda = p[3:0];
                @(negedge clk);
                chk(int'($signed(rdd)) == keep[p], "R3 out of extent unchanged",
                    int'($signed(rdd)), keep[p]);
            end
        end

        // R6: positive clamp, then one step down from the clamp
        do_clear();
        for (int i = 0; i < 257; i++) run_rect('{1, 0, 0, 100, 100}, 0);
        chk(mdl[5] == PMAX, "R6 model at positive clamp", mdl[5], PMAX);
        readback("R6 positive saturation");
        run_rect('{1, -100, 0, 0, 100}, 1);
        readback("R6 step down from clamp");

        // R6: negative clamp
        do_clear();
        for (int i = 0; i < 257; i++) run_rect('{1, -100, 0, 0, 100}, 0);
        chk(mdl[0] == PMIN, "R6 model at negative clamp", mdl[0], PMIN);
        readback("R6 negative saturation");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule